// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block identifies an attached monitor through three shared identification wires, called A, B and C here. Each wire has an external pull-up, and the monitor ties the wires together or to ground through its own network. The block controls the wires through per-line output enables and output levels, waits a settle time after every change, samples the wires, and packs the samples into a nine-bit code.

A one-cycle `start` pulse launches the probe. First all three wires are driven high for a short precharge, and then every driver is released. After a long settle the idle levels are sampled. Next, each wire in turn is pulled low while the other two are sampled. At the end all drivers are released again, and `done` pulses with the finished code. Line inputs pass through a two-flop synchronizer before they are sampled.

Top module: `mon_sense_seq`

## Requirements
- R1: After reset `busy`, `done`, `drive_oe` and `code` are all zero.
- R2: A `start` pulse while idle begins a precharge of exactly SHORT_SETTLE cycles with `drive_oe` = 3'b111 and `drive_lvl` = 3'b111. `drive_lvl` is never nonzero outside this phase.
- R3: Next, all drivers are released (`drive_oe` = 0) for LONG_SETTLE cycles. The synchronized levels of C, B and A are then stored in `code[8]`, `code[7]` and `code[6]`.
- R4: Next, A alone is pulled low (`drive_oe` = 3'b001, `drive_lvl` = 0) for LONG_SETTLE cycles. C is then stored in `code[5]` and B in `code[4]`.
- R5: Next, B alone is pulled low (`drive_oe` = 3'b010) for LONG_SETTLE cycles. C is then stored in `code[3]` and A in `code[2]`.
- R6: Next, C alone is pulled low (`drive_oe` = 3'b100) for LONG_SETTLE cycles. B is then stored in `code[1]` and A in `code[0]`.
- R7: After the last sample all drivers are released and `done` is high for exactly one cycle with the new `code`. `code` does not change at any other time.
- R8: `busy` is high for exactly SHORT_SETTLE + 4*LONG_SETTLE cycles, starting in the cycle after the accepted `start`.
- R9: A `start` pulse while `busy` is ignored. The sequence length, the single `done` and the code are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| line_in | input | 3 | Sensed wire levels, bit 0 = A, bit 1 = B, bit 2 = C |
| drive_oe | output | 3 | Per-wire output enable, same bit order |
| drive_lvl | output | 3 | Level driven on enabled wires |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| code | output | 9 | Packed sense code |

## Verification
The bench builds the block with SHORT_SETTLE = 2 and LONG_SETTLE = 4. With these values one probe takes 18 cycles, and the bench can sweep every combination of wire-to-ground shorts and wire-to-wire links: 64 monitor networks. Each expected code comes from a resistive network model evaluated under the four drive patterns. The drive pattern is checked in every cycle of every phase, and one run injects a `start` pulse partway through to show that it is ignored.

// File: rtl/mon_sense_seq.sv
module mon_sense_seq #(
  parameter int SHORT_SETTLE = 200,
  parameter int LONG_SETTLE  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] line_in,
  output logic [2:0] drive_oe,
  output logic [2:0] drive_lvl,
  output logic       busy,
  output logic       done,
  output logic [8:0] code
);
  localparam int MAXD = (SHORT_SETTLE > LONG_SETTLE) ? SHORT_SETTLE : LONG_SETTLE;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_SETTLE - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_SETTLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_HIGH, S_REL, S_LOA, S_LOB, S_LOC} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [2:0]    sync1, sync2;
  logic [8:2]    acc;
  wire           last = (cnt == '0);

  assign busy      = (state != S_IDLE);
  assign drive_lvl = (state == S_HIGH) ? 3'b111 : 3'b000;
  assign drive_oe  = (state == S_HIGH) ? 3'b111 :
                     (state == S_LOA)  ? 3'b001 :
                     (state == S_LOB)  ? 3'b010 :
                     (state == S_LOC)  ? 3'b100 : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      sync1 <= '0;
      sync2 <= '0;
      acc   <= '0;
      code  <= '0;
      done  <= 1'b0;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      done  <= 1'b0;
      if (state != S_IDLE && !last) cnt <= cnt - 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state <= S_HIGH;
          cnt   <= SHORT_M1;
        end
        S_HIGH: if (last) begin
          state <= S_REL;
          cnt   <= LONG_M1;
        end
        S_REL: if (last) begin
          acc[8:6] <= sync2;
          state    <= S_LOA;
          cnt      <= LONG_M1;
        end
        S_LOA: if (last) begin
          acc[5:4] <= {sync2[2], sync2[1]};
          state    <= S_LOB;
          cnt      <= LONG_M1;
        end
        S_LOB: if (last) begin
          acc[3:2] <= {sync2[2], sync2[0]};
          state    <= S_LOC;
          cnt      <= LONG_M1;
        end
        S_LOC: if (last) begin
          code  <= {acc, sync2[1], sync2[0]};
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module mon_sense_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] drive_oe,
  input logic [2:0] drive_lvl,
  input logic       busy,
  input logic       done,
  input logic [8:0] code
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> drive_oe == 3'b000);
  assert_high_only_precharge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_lvl != 3'b000) |-> (drive_oe == 3'b111 && drive_lvl == 3'b111));
  assert_single_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_oe != 3'b111) |-> $onehot0(drive_oe));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && drive_oe == 3'b000));
  assert_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done || 1'b1) && ($stable(code) || $past(busy)));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind mon_sense_seq mon_sense_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .drive_oe(drive_oe),
  .drive_lvl(drive_lvl), .busy(busy), .done(done), .code(code));

// File: tb/tb_mon_sense_seq.sv
module tb_mon_sense_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SH  = 2;
  localparam int LG  = 4;
  localparam int TOT = SH + 4 * LG;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] line_in;
  logic [2:0] drive_oe, drive_lvl;
  logic       busy, done;
  logic [8:0] code;
  logic [2:0] gnd = 3'b000;
  logic [2:0] link = 3'b000;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         n_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_sense_seq #(.SHORT_SETTLE(SH), .LONG_SETTLE(LG)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .line_in(line_in),
    .drive_oe(drive_oe), .drive_lvl(drive_lvl), .busy(busy),
    .done(done), .code(code));

  // link[0]: A-B, link[1]: B-C, link[2]: A-C
  function automatic logic tied(int i, int j, logic [2:0] l);
    if ((i == 0 && j == 1) || (i == 1 && j == 0)) return l[0];
    if ((i == 1 && j == 2) || (i == 2 && j == 1)) return l[1];
    if ((i == 0 && j == 2) || (i == 2 && j == 0)) return l[2];
    return 1'b0;
  endfunction

  function automatic logic [2:0] net(logic [2:0] oe, logic [2:0] lvl,
                                     logic [2:0] g, logic [2:0] l);
    logic [2:0] src, v;
    for (int i = 0; i < 3; i++) src[i] = oe[i] ? ~lvl[i] : g[i];
    for (int i = 0; i < 3; i++) begin
      if (oe[i]) v[i] = lvl[i];
      else begin
        v[i] = ~g[i];
        for (int j = 0; j < 3; j++) if (tied(i, j, l) && src[j]) v[i] = 1'b0;
      end
    end
    return v;
  endfunction

  always_comb line_in = net(drive_oe, drive_lvl, gnd, link);

  always @(posedge clk) if (rst_n && done) n_done++;

  task automatic chk(int act, int exp, string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (gnd=%b link=%b)", req, act, exp, gnd, link);
    end
  endtask

  task automatic run(bit extra);
    logic [2:0] i0, a, b, c;
    logic [8:0] exp;
    int d0;
    i0 = net(3'b000, 3'b000, gnd, link);
    a  = net(3'b001, 3'b000, gnd, link);
    b  = net(3'b010, 3'b000, gnd, link);
    c  = net(3'b100, 3'b000, gnd, link);
    exp = {i0[2], i0[1], i0[0], a[2], a[1], b[2], b[0], c[1], c[0]};
    d0 = n_done;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= TOT + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= SH)              chk({drive_oe, drive_lvl}, 6'b111111, "R2");
      else if (k <= SH + LG)    chk({drive_oe, drive_lvl}, 6'b000000, "R3");
      else if (k <= SH + 2*LG)  chk({drive_oe, drive_lvl}, 6'b001000, "R4");
      else if (k <= SH + 3*LG)  chk({drive_oe, drive_lvl}, 6'b010000, "R5");
      else if (k <= TOT)        chk({drive_oe, drive_lvl}, 6'b100000, "R6");
      else                      chk({drive_oe, drive_lvl}, 6'b000000, "R7");
      chk(busy, (k <= TOT) ? 1 : 0, "R8");
      chk(done, (k == TOT + 1) ? 1 : 0, "R7");
      start = (extra && k == 5);
    end
    start = 1'b0;
    chk(code[8:6], exp[8:6], "R3");
    chk(code[5:4], exp[5:4], "R4");
    chk(code[3:2], exp[3:2], "R5");
    chk(code[1:0], exp[1:0], "R6");
    repeat (LG + 2) @(negedge clk);
    chk(busy, 0, extra ? "R9" : "R8");
    chk(n_done - d0, 1, extra ? "R9" : "R7");
    chk(code, exp, extra ? "R9" : "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, drive_oe}, 0, "R1");
    chk(code, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, drive_oe, drive_lvl}, 0, "R1");
    for (int g = 0; g < 8; g++)
      for (int l = 0; l < 8; l++) begin
        gnd  = 3'(g);
        link = 3'(l);
        run(1'b0);
      end
    gnd  = 3'b010;
    link = 3'b100;
    run(1'b1);
    gnd  = 3'b000;
    link = 3'b011;
    run(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule